// File: doc/BRIEF.md
# Fixed-Off-Time Bridge Chopper Controller

This block is the digital controller for one H-bridge winding. It turns a direction bit, a two-bit current-level code, a sense-comparator trip and a die-temperature code into four gate enables: high-side (source) and low-side (sink) for each bridge side. While the bridge drives, the source of one side and the sink of the other side are both on. When the winding current reaches the trip level, the comparator fires. The controller then turns off only the active source for a programmed number of clock cycles. The sink stays on, so the current recirculates and decays slowly. After that interval the source turns back on, and the cycle repeats to hold the average current.

A direction change never reaches the bridge directly. The controller passes through an all-off gap of programmed length first. After every source turn-on, comparator trips can be masked for a programmed blanking window, which rejects current spikes from load capacitance. The level code `11` switches all four drivers off, which gives fast decay and serves as an output enable. The other three level codes only select the reference level, which lies outside this block. A temperature code at or above a hot threshold shuts the bridge down. It stays down until the code falls to a lower resume threshold.

The controller is a five-state machine:
- `ST_OFF`: all drivers off.
- `ST_DEAD`: all off for the gap, then the new direction is latched.
- `ST_BLANK`: driving with trips masked.
- `ST_DRIVE`: driving with trips honoured.
- `ST_CHOP`: only the sink of the active leg is on.

The transitions are:
- From any state to `ST_OFF` on shutdown (level code `11` or thermal).
- `ST_OFF` to `ST_DEAD` on release.
- From `ST_BLANK`, `ST_DRIVE` or `ST_CHOP` to `ST_DEAD` when the direction changes.
- `ST_DEAD` to `ST_BLANK`, or to `ST_DRIVE` when the blank count is zero, when the gap expires.
- `ST_BLANK` to `ST_DRIVE` when the window expires.
- `ST_DRIVE` to `ST_CHOP` on a trip.
- `ST_CHOP` to `ST_BLANK` or `ST_DRIVE` when the off-time expires.

Top module: `hbridge_chopper`

## Requirements
- R1: While reset is asserted, all four enables are 0. The registered copies of the direction and level inputs reset to 1 and `11`, so the bridge stays off until real inputs have been sampled.
- R2: Bit order {a_src_o, a_snk_o, b_src_o, b_snk_o}. When driving with direction 1, the outputs are `1001` (side A source, side B sink). When driving with direction 0, they are `0110`. Level codes `00`, `01` and `10` all drive.
- R3: Level code `11` on `lvl_i` turns all enables off from the second rising edge after it is applied. Leaving `11` starts a dead interval before any turn-on.
- R4: In `ST_DRIVE`, a high `trip_i` goes through a two-flop synchronizer. On the third rising edge after it is applied, the active source turns off while the opposite sink stays on (`0001` for direction 1). This lasts max(`off_cyc_i`,1) cycles, after which the source turns back on.
- R5: After each source turn-on, trips are ignored for `blank_cyc_i` cycles. A zero count removes the window. Trips are also ignored during the off-time, which a trip never extends. A trip held high re-chops as soon as the window ends.
- R6: A change of `dir_i` while driving or chopping gives all-off outputs from the second rising edge, for max(`dead_cyc_i`,1) cycles. Driving then resumes in the new direction. Shutdown has priority over a direction change, which has priority over a trip or a timer.
- R7: A `temp_i` value of `T_HOT` (170) or higher turns all enables off from the second rising edge. They stay off while `temp_i` is above `T_COOL` (145). Once `temp_i` is at or below `T_COOL`, a dead interval runs and driving resumes.
- R8: The source and sink of the same side are never on together. A source is on only while the opposite sink is on, and the drive legs of the two directions are never on in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Winding current direction |
| lvl_i | input | 2 | Current-level code; `11` disables all drivers |
| trip_i | input | 1 | Asynchronous sense-comparator trip |
| temp_i | input | TEMP_W | Die temperature code |
| off_cyc_i | input | CNT_W | Off-time length in clock cycles |
| dead_cyc_i | input | CNT_W | Dead interval length in clock cycles |
| blank_cyc_i | input | CNT_W | Trip blanking window in cycles; 0 disables it |
| a_src_o | output | 1 | Side A high-side enable |
| a_snk_o | output | 1 | Side A low-side enable |
| b_src_o | output | 1 | Side B high-side enable |
| b_snk_o | output | 1 | Side B low-side enable |

## Verification
A direction change can arrive while an off-time is running. A trip held high can land on the same cycle that a blanking window expires. The bench produces the first case by pulsing a trip and then flipping direction one cycle after the chop starts. The expected result is that the chop is abandoned for a full dead interval and the drive resumes on the opposite leg. It produces the second case by holding the trip through a whole chop and blank period. The expected result is that the re-chop comes exactly one cycle after the window closes, or directly after the off-time when the window length is zero.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_DEAD,
        ST_BLANK,
        ST_DRIVE,
        ST_CHOP
    } hbc_state_e;

    localparam logic [1:0] LVL_KILL = 2'b11;
endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbc_timer.sv
module hbc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt > W'(1))    cnt <= cnt - W'(1);
    end

    // interval length is max(load_val,1) cycles
    assign done = (cnt <= W'(1));
endmodule

// File: rtl/hbc_thermal.sv
module hbc_thermal #(
    parameter int TW     = 8,
    parameter int T_HOT  = 170,
    parameter int T_COOL = 145
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp,
    output logic          hot
);
    localparam logic [TW-1:0] HOT_C  = TW'(T_HOT);
    localparam logic [TW-1:0] COOL_C = TW'(T_COOL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              hot <= 1'b0;
        else if (temp >= HOT_C)  hot <= 1'b1;
        else if (temp <= COOL_C) hot <= 1'b0;
    end
endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
    import hbc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int TEMP_W      = 8,
    parameter int T_HOT       = 170,
    parameter int T_COOL      = 145,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_i,
    input  logic [1:0]        lvl_i,
    input  logic              trip_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [CNT_W-1:0]  off_cyc_i,
    input  logic [CNT_W-1:0]  dead_cyc_i,
    input  logic [CNT_W-1:0]  blank_cyc_i,
    output logic              a_src_o,
    output logic              a_snk_o,
    output logic              b_src_o,
    output logic              b_snk_o
);
    hbc_state_e       state, nxt;
    logic             dir_q, dir_act, dir_act_nxt;
    logic [1:0]       lvl_q;
    logic             trip_s, hot, kill;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;

    // input capture: defaults high so the bridge starts disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= 1'b1;
            lvl_q <= LVL_KILL;
        end else begin
            dir_q <= dir_i;
            lvl_q <= lvl_i;
        end
    end

    hbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(trip_i), .q(trip_s)
    );

    hbc_thermal #(.TW(TEMP_W), .T_HOT(T_HOT), .T_COOL(T_COOL)) u_therm (
        .clk(clk), .rst_n(rst_n), .temp(temp_i), .hot(hot)
    );

    hbc_timer #(.W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .done(tmr_done)
    );

    assign kill = hot || (lvl_q == LVL_KILL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            dir_act <= 1'b1;
        end else begin
            state   <= nxt;
            dir_act <= dir_act_nxt;
        end
    end

    // next state: shutdown > direction change > trip / timers
    always_comb begin
        nxt         = state;
        dir_act_nxt = dir_act;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        if (kill) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    nxt      = ST_DEAD;
                    tmr_load = 1'b1;
                    tmr_val  = dead_cyc_i;
                end
                ST_DEAD: begin
                    if (tmr_done) begin
                        dir_act_nxt = dir_q;
                        if (blank_cyc_i != '0) begin
                            nxt      = ST_BLANK;
                            tmr_load = 1'b1;
                            tmr_val  = blank_cyc_i;
                        end else begin
                            nxt = ST_DRIVE;
                        end
                    end
                end
                ST_BLANK, ST_DRIVE, ST_CHOP: begin
                    if (dir_q != dir_act) begin
                        nxt      = ST_DEAD;
                        tmr_load = 1'b1;
                        tmr_val  = dead_cyc_i;
                    end else if (state == ST_BLANK) begin
                        if (tmr_done) nxt = ST_DRIVE;
                    end else if (state == ST_DRIVE) begin
                        if (trip_s) begin
                            nxt      = ST_CHOP;
                            tmr_load = 1'b1;
                            tmr_val  = off_cyc_i;
                        end
                    end else if (tmr_done) begin
                        if (blank_cyc_i != '0) begin
                            nxt      = ST_BLANK;
                            tmr_load = 1'b1;
                            tmr_val  = blank_cyc_i;
                        end else begin
                            nxt = ST_DRIVE;
                        end
                    end
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    // output decode
    always_comb begin
        a_src_o = 1'b0;
        a_snk_o = 1'b0;
        b_src_o = 1'b0;
        b_snk_o = 1'b0;
        unique case (state)
            ST_BLANK, ST_DRIVE: begin
                a_src_o = dir_act;
                b_snk_o = dir_act;
                b_src_o = !dir_act;
                a_snk_o = !dir_act;
            end
            ST_CHOP: begin
                b_snk_o = dir_act;
                a_snk_o = !dir_act;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hbc_checker.sv
module hbc_checker #(
    parameter int TEMP_W = 8,
    parameter int T_HOT  = 170
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        lvl_i,
    input logic [TEMP_W-1:0] temp_i,
    input logic              a_src_o,
    input logic              a_snk_o,
    input logic              b_src_o,
    input logic              b_snk_o
);
    logic any_on;
    assign any_on = a_src_o || a_snk_o || b_src_o || b_snk_o;

    a_r8_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_src_o && a_snk_o) && !(b_src_o && b_snk_o));

    a_r8_a_src_pair: assert property (@(posedge clk) disable iff (!rst_n)
        a_src_o |-> b_snk_o);

    a_r8_b_src_pair: assert property (@(posedge clk) disable iff (!rst_n)
        b_src_o |-> a_snk_o);

    a_r6_gap_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (a_src_o || b_snk_o) |-> !$past(b_src_o || a_snk_o));

    a_r6_gap_rev: assert property (@(posedge clk) disable iff (!rst_n)
        (b_src_o || a_snk_o) |-> !$past(a_src_o || b_snk_o));

    a_r3_kill_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lvl_i, 2) == 2'b11) |-> !any_on);

    a_r7_hot_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(temp_i >= TEMP_W'(T_HOT), 2) |-> !any_on);
endmodule

bind hbridge_chopper hbc_checker #(.TEMP_W(TEMP_W), .T_HOT(T_HOT)) u_chk (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i), .temp_i(temp_i),
    .a_src_o(a_src_o), .a_snk_o(a_snk_o), .b_src_o(b_src_o), .b_snk_o(b_snk_o)
);

// File: tb/hbridge_chopper_test.sv
module hbridge_chopper_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_i = 1'b1;
    logic [1:0] lvl_i = 2'b11;
    logic       trip_i = 1'b0;
    logic [7:0] temp_i = 8'd25;
    logic [7:0] off_cyc_i = 8'd5;
    logic [7:0] dead_cyc_i = 8'd4;
    logic [7:0] blank_cyc_i = 8'd3;
    logic       a_src_o, a_snk_o, b_src_o, b_snk_o;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    hbridge_chopper uut (
        .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .lvl_i(lvl_i),
        .trip_i(trip_i), .temp_i(temp_i), .off_cyc_i(off_cyc_i),
        .dead_cyc_i(dead_cyc_i), .blank_cyc_i(blank_cyc_i),
        .a_src_o(a_src_o), .a_snk_o(a_snk_o),
        .b_src_o(b_src_o), .b_snk_o(b_snk_o)
    );

    // {dir, lvl, temp, wait, expected {a_src,a_snk,b_src,b_snk}}
    localparam int NV = 12;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 2'b00, 8'd25,  6'd20, 4'b1001},
        {1'b0, 2'b00, 8'd25,  6'd20, 4'b0110},
        {1'b0, 2'b11, 8'd25,  6'd5,  4'b0000},
        {1'b0, 2'b10, 8'd25,  6'd20, 4'b0110},
        {1'b1, 2'b01, 8'd25,  6'd20, 4'b1001},
        {1'b1, 2'b01, 8'd170, 6'd5,  4'b0000},
        {1'b1, 2'b01, 8'd160, 6'd20, 4'b0000},
        {1'b1, 2'b01, 8'd145, 6'd20, 4'b1001},
        {1'b1, 2'b01, 8'd169, 6'd20, 4'b1001},
        {1'b1, 2'b11, 8'd200, 6'd5,  4'b0000},
        {1'b1, 2'b00, 8'd150, 6'd20, 4'b0000},
        {1'b1, 2'b00, 8'd30,  6'd20, 4'b1001}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [3:0] exp, input string tag);
        logic [3:0] got;
        got = {a_src_o, a_snk_o, b_src_o, b_snk_o};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic run(input int n, input logic [3:0] exp, input string tag);
        for (int k = 0; k < n; k++) begin
            tick();
            chk(exp, tag);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(4'b0000, "R1 in reset");
        rst_n = 1'b1;

        // table: R2 mapping, R3 level kill, R7 thermal hysteresis, R8
        for (int i = 0; i < NV; i++) begin
            dir_i  = VEC[i][20];
            lvl_i  = VEC[i][19:18];
            temp_i = VEC[i][17:10];
            repeat (int'(VEC[i][9:4])) tick();
            chk(VEC[i][3:0], $sformatf("R2/R3/R7/R8 vector %0d", i));
        end

        // R4 single trip pulse, R5 pulse during off-time is ignored
        trip_i = 1'b1; run(1, 4'b1001, "R4 sync stage 1");
        trip_i = 1'b0; run(1, 4'b1001, "R4 sync stage 2");
        run(1, 4'b0001, "R4 chop entered");
        trip_i = 1'b1; run(1, 4'b0001, "R5 trip during off-time");
        trip_i = 1'b0; run(3, 4'b0001, "R5 off-time not extended");
        run(1, 4'b1001, "R4 source re-enabled");
        run(4, 4'b1001, "R5 blank masks trip");

        // R5 held trip with blanking
        trip_i = 1'b1;
        run(2, 4'b1001, "R4 held trip latency");
        run(5, 4'b0001, "R4 off-time length");
        run(4, 4'b1001, "R5 blank window");
        run(1, 4'b0001, "R5 rechop after blank");
        trip_i = 1'b0;
        repeat (20) tick();
        chk(4'b1001, "R5 settle");

        // R5 zero blank count removes the window
        blank_cyc_i = 8'd0; trip_i = 1'b1;
        run(2, 4'b1001, "R5 zero blank latency");
        run(5, 4'b0001, "R5 zero blank off-time");
        run(1, 4'b1001, "R5 zero blank drive");
        run(1, 4'b0001, "R5 zero blank immediate rechop");
        trip_i = 1'b0; blank_cyc_i = 8'd3;
        repeat (20) tick();
        chk(4'b1001, "R5 settle 2");

        // R6 direction change during off-time
        trip_i = 1'b1; run(1, 4'b1001, "R6 trip pulse");
        trip_i = 1'b0; run(1, 4'b1001, "R6 trip pulse 2");
        run(1, 4'b0001, "R6 chop before change");
        dir_i = 1'b0;
        run(1, 4'b0001, "R6 dir registered");
        run(4, 4'b0000, "R6 dead abandons chop");
        run(1, 4'b0110, "R6 new direction");

        // R3 exact kill latency and dead on release
        lvl_i = 2'b11; run(1, 4'b0110, "R3 before kill");
        run(1, 4'b0000, "R3 kill");
        lvl_i = 2'b00; run(5, 4'b0000, "R3 dead after release");
        run(1, 4'b0110, "R3 resume");

        // R7 exact thermal latency and hysteresis
        temp_i = 8'd170; run(1, 4'b0110, "R7 before hot");
        run(1, 4'b0000, "R7 hot off");
        temp_i = 8'd150; run(10, 4'b0000, "R7 hysteresis hold");
        temp_i = 8'd145; run(5, 4'b0000, "R7 cool then dead");
        run(1, 4'b0110, "R7 resume");

        // R6 zero dead count gives one cycle
        dead_cyc_i = 8'd0;
        repeat (10) tick();
        dir_i = 1'b1; run(1, 4'b0110, "R6 min dead pre");
        run(1, 4'b0000, "R6 min dead one cycle");
        run(1, 4'b1001, "R6 min dead done");
        dead_cyc_i = 8'd4;
        repeat (10) tick();

        // R6 plain direction change
        dir_i = 1'b0; run(1, 4'b1001, "R6 pre change");
        run(4, 4'b0000, "R6 dead interval");
        run(1, 4'b0110, "R6 reversed");

        // R1 reset mid-run and default-off start
        rst_n = 1'b0; #1;
        chk(4'b0000, "R1 async reset");
        tick();
        rst_n = 1'b1;
        run(1, 4'b0000, "R1 default off after release");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule